// File: doc/BRIEF.md
# Multichannel Delay-Gain Beam Combiner

This block forms one receive beam from eight complex baseband channels. Each channel arrives as an I stream and a Q stream. Every clock word carries eight consecutive samples of each stream, lane 0 holding the oldest. For every channel the block shifts the stream by a programmable whole number of samples, from zero to seven. It then scales the stream by a programmable unsigned gain weight, which serves as an amplitude taper or as a level correction between channels. Finally it adds the eight weighted channels, lane by lane, into a single complex beam word of the same parallel width.

A host processor loads steering values through a small write port. Each write lands in a shadow copy of the settings. A separate commit strobe moves every shadow delay and gain into the working set on the same edge. A new beam direction therefore never mixes old and new values for different channels. An input word uses the delays and gains that were in force on the edge where it was accepted, and it keeps them through the whole pipeline. The result appears three clocks later, marked by an output valid.

Top module: `beam_combiner`

## Requirements
- R1: After a synchronous reset, out_valid is low, every channel delay is 0 and every gain is 0x8000 (1.0 in Q1.15). The first words after reset therefore give the plain saturated sum of the channels, and the history before the first accepted word reads as zero.
- R2: With delay d on a channel, output lane k of word t takes that channel's stream sample at index 8t+k-d, where lane 0 is the oldest sample of a word. When k-d is negative the sample comes from lane 8+k-d of the previous accepted word.
- R3: A gain g is unsigned Q1.15. The weighted sample is (s*g + 2^14) >> 15, an arithmetic shift, saturated to the signed 16-bit range.
- R4: For each lane, the weighted samples of all eight channels are added at full width, 19 bits, and the sum is saturated to the signed 16-bit output range.
- R5: out_valid is high exactly three clocks after each clock with in_valid high. Words with in_valid low do not advance the per-channel sample history, so gaps in valid do not shift the alignment.
- R6: A write with cfg_wr high changes only the shadow settings. Outputs keep using the working settings until a commit.
- R7: On a cfg_commit edge, all shadow delays and gains become the working set at once. A word accepted on that same edge still uses the previous working set, and a write on that same edge goes to the shadow only.
- R8: The Q stream passes through the same delay, gain, rounding and summation as the I stream, with the same settings.
- R9: Writes are selected by cfg_sel: 0 writes a delay, 1 writes a gain. A delay write uses only cfg_data[2:0]; the upper data bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input words on in_i/in_q are valid |
| in_i | input | 1024 | I samples, channel-major, 8 lanes of 16 bits per channel, lane 0 oldest |
| in_q | input | 1024 | Q samples, same layout as in_i |
| cfg_wr | input | 1 | Write one shadow setting |
| cfg_sel | input | 1 | 0 selects delay, 1 selects gain |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_data | input | 16 | Gain (Q1.15 unsigned) or delay in bits 2:0 |
| cfg_commit | input | 1 | Copy all shadow settings to the working set |
| out_valid | output | 1 | Beam word valid |
| out_i | output | 128 | Beam I samples, 8 lanes of 16 bits, lane 0 oldest |
| out_q | output | 128 | Beam Q samples, same layout |

## Verification
The assertions check the control side on every cycle. They confirm that the valid flag trails the input valid by exactly three clocks and that the working settings stay frozen without a commit. They also confirm that a commit copies the shadow values and that reset restores unity gains. The arithmetic can only be shown by the bench's scenarios: the cross-word sample window, rounding, both saturation points, and a commit landing on the same edge as a data word and a write. The bench compares every beam word against a model built from the requirements, using random data, random gaps and random steering updates.

// File: rtl/bc_pkg.sv
package bc_pkg;

  typedef enum logic {
    CFG_DELAY = 1'b0,
    CFG_GAIN  = 1'b1
  } cfg_sel_e;

endpackage

// File: rtl/bc_cfg_bank.sv
module bc_cfg_bank
  import bc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DLY_W  = 3,
  parameter int GAIN_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_wr,
  input  cfg_sel_e                 cfg_sel,
  input  logic [CH_W-1:0]          cfg_ch,
  input  logic [GAIN_W-1:0]        cfg_data,
  input  logic                     cfg_commit,
  output logic [NUM_CH*DLY_W-1:0]  shd_dly,
  output logic [NUM_CH*GAIN_W-1:0] shd_gain,
  output logic [NUM_CH*DLY_W-1:0]  act_dly,
  output logic [NUM_CH*GAIN_W-1:0] act_gain
);

  localparam logic [GAIN_W-1:0] UNITY = {1'b1, {(GAIN_W-1){1'b0}}};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = cfg_wr && (cfg_ch == CH_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        shd_dly[c*DLY_W +: DLY_W]   <= '0;
        shd_gain[c*GAIN_W +: GAIN_W] <= UNITY;
      end else if (hit) begin
        if (cfg_sel == CFG_DELAY) shd_dly[c*DLY_W +: DLY_W] <= cfg_data[DLY_W-1:0];
        else                      shd_gain[c*GAIN_W +: GAIN_W] <= cfg_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        act_dly[c*DLY_W +: DLY_W]   <= '0;
        act_gain[c*GAIN_W +: GAIN_W] <= UNITY;
      end else if (cfg_commit) begin
        act_dly[c*DLY_W +: DLY_W]   <= shd_dly[c*DLY_W +: DLY_W];
        act_gain[c*GAIN_W +: GAIN_W] <= shd_gain[c*GAIN_W +: GAIN_W];
      end
    end
  end

endmodule

// File: rtl/bc_lane_align.sv
module bc_lane_align #(
  parameter int LANES  = 8,
  parameter int SAMP_W = 16,
  parameter int DLY_W  = 3,
  localparam int WORD_W = LANES * SAMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] din_i,
  input  logic [WORD_W-1:0] din_q,
  input  logic [DLY_W-1:0]  dly,
  output logic [WORD_W-1:0] dout_i,
  output logic [WORD_W-1:0] dout_q
);

  logic [WORD_W-1:0]   prev_i, prev_q;
  logic [2*WORD_W-1:0] cat_i, cat_q;
  logic [WORD_W-1:0]   win_i, win_q;

  // older word in the low half, newer word in the high half
  assign cat_i = {din_i, prev_i};
  assign cat_q = {din_q, prev_q};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign win_i[k*SAMP_W +: SAMP_W] = cat_i[(LANES + k - int'(dly))*SAMP_W +: SAMP_W];
    assign win_q[k*SAMP_W +: SAMP_W] = cat_q[(LANES + k - int'(dly))*SAMP_W +: SAMP_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_i <= '0;
      prev_q <= '0;
      dout_i <= '0;
      dout_q <= '0;
    end else if (in_valid) begin
      prev_i <= din_i;
      prev_q <= din_q;
      dout_i <= win_i;
      dout_q <= win_q;
    end
  end

endmodule

// File: rtl/bc_weight.sv
module bc_weight #(
  parameter int LANES  = 8,
  parameter int SAMP_W = 16,
  parameter int GAIN_W = 16,
  localparam int WORD_W = LANES * SAMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [WORD_W-1:0] din_i,
  input  logic [WORD_W-1:0] din_q,
  input  logic [GAIN_W-1:0] gain,
  output logic [WORD_W-1:0] dout_i,
  output logic [WORD_W-1:0] dout_q
);

  localparam int PROD_W = SAMP_W + GAIN_W + 1;
  localparam int FRAC   = GAIN_W - 1;
  localparam int HEAD_W = PROD_W - SAMP_W + 1;
  localparam logic signed [PROD_W-1:0] RND = PROD_W'(1) <<< (FRAC - 1);

  function automatic logic [SAMP_W-1:0] clip(input logic signed [PROD_W-1:0] v);
    logic [HEAD_W-1:0] head;
    head = v[PROD_W-1 -: HEAD_W];
    if ((&head) || !(|head)) return v[SAMP_W-1:0];
    return v[PROD_W-1] ? {1'b1, {(SAMP_W-1){1'b0}}} : {1'b0, {(SAMP_W-1){1'b1}}};
  endfunction

  logic signed [GAIN_W:0] g_s;
  assign g_s = $signed({1'b0, gain});

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [PROD_W-1:0] p_i, p_q, r_i, r_q;
    assign p_i = $signed(din_i[k*SAMP_W +: SAMP_W]) * g_s;
    assign p_q = $signed(din_q[k*SAMP_W +: SAMP_W]) * g_s;
    assign r_i = (p_i + RND) >>> FRAC;
    assign r_q = (p_q + RND) >>> FRAC;

    always_ff @(posedge clk) begin
      if (rst) begin
        dout_i[k*SAMP_W +: SAMP_W] <= '0;
        dout_q[k*SAMP_W +: SAMP_W] <= '0;
      end else if (en) begin
        dout_i[k*SAMP_W +: SAMP_W] <= clip(r_i);
        dout_q[k*SAMP_W +: SAMP_W] <= clip(r_q);
      end
    end
  end

endmodule

// File: rtl/bc_sum_tree.sv
module bc_sum_tree #(
  parameter int NUM_CH = 8,
  parameter int LANES  = 8,
  parameter int SAMP_W = 16,
  parameter int OUT_W  = 16,
  localparam int WORD_W = LANES * SAMP_W,
  localparam int OWORD_W = LANES * OUT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [NUM_CH*WORD_W-1:0] din_i,
  input  logic [NUM_CH*WORD_W-1:0] din_q,
  output logic [OWORD_W-1:0]       dout_i,
  output logic [OWORD_W-1:0]       dout_q
);

  localparam int SUM_W  = SAMP_W + $clog2(NUM_CH);
  localparam int HEAD_W = SUM_W - OUT_W + 1;

  function automatic logic [OUT_W-1:0] clip(input logic signed [SUM_W-1:0] v);
    logic [HEAD_W-1:0] head;
    head = v[SUM_W-1 -: HEAD_W];
    if ((&head) || !(|head)) return v[OUT_W-1:0];
    return v[SUM_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [SUM_W-1:0] acc_i, acc_q;

    always_comb begin
      acc_i = '0;
      acc_q = '0;
      for (int c = 0; c < NUM_CH; c++) begin
        acc_i = acc_i + SUM_W'($signed(din_i[c*WORD_W + k*SAMP_W +: SAMP_W]));
        acc_q = acc_q + SUM_W'($signed(din_q[c*WORD_W + k*SAMP_W +: SAMP_W]));
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        dout_i[k*OUT_W +: OUT_W] <= '0;
        dout_q[k*OUT_W +: OUT_W] <= '0;
      end else if (en) begin
        dout_i[k*OUT_W +: OUT_W] <= clip(acc_i);
        dout_q[k*OUT_W +: OUT_W] <= clip(acc_q);
      end
    end
  end

endmodule

// File: rtl/beam_combiner.sv
module beam_combiner
  import bc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int LANES  = 8,
  parameter int SAMP_W = 16,
  parameter int GAIN_W = 16,
  parameter int OUT_W  = 16,
  localparam int DLY_W  = $clog2(LANES),
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int WORD_W = LANES * SAMP_W,
  localparam int BUS_W  = NUM_CH * WORD_W,
  localparam int OWORD_W = LANES * OUT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [BUS_W-1:0]   in_i,
  input  logic [BUS_W-1:0]   in_q,
  input  logic               cfg_wr,
  input  logic               cfg_sel,
  input  logic [CH_W-1:0]    cfg_ch,
  input  logic [GAIN_W-1:0]  cfg_data,
  input  logic               cfg_commit,
  output logic               out_valid,
  output logic [OWORD_W-1:0] out_i,
  output logic [OWORD_W-1:0] out_q
);

  logic [NUM_CH*DLY_W-1:0]  shd_dly, act_dly;
  logic [NUM_CH*GAIN_W-1:0] shd_gain, act_gain, gain_s1;
  logic [BUS_W-1:0]         al_i, al_q, wt_i, wt_q;
  logic                     v1, v2;

  bc_cfg_bank #(
    .NUM_CH(NUM_CH), .DLY_W(DLY_W), .GAIN_W(GAIN_W)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel_e'(cfg_sel)), .cfg_ch(cfg_ch),
    .cfg_data(cfg_data), .cfg_commit(cfg_commit),
    .shd_dly(shd_dly), .shd_gain(shd_gain),
    .act_dly(act_dly), .act_gain(act_gain)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bc_lane_align #(
      .LANES(LANES), .SAMP_W(SAMP_W), .DLY_W(DLY_W)
    ) u_align (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .din_i(in_i[c*WORD_W +: WORD_W]), .din_q(in_q[c*WORD_W +: WORD_W]),
      .dly(act_dly[c*DLY_W +: DLY_W]),
      .dout_i(al_i[c*WORD_W +: WORD_W]), .dout_q(al_q[c*WORD_W +: WORD_W])
    );

    // gain travels with the word so delay and gain come from one set
    always_ff @(posedge clk) begin
      if (rst) gain_s1[c*GAIN_W +: GAIN_W] <= '0;
      else if (in_valid) gain_s1[c*GAIN_W +: GAIN_W] <= act_gain[c*GAIN_W +: GAIN_W];
    end

    bc_weight #(
      .LANES(LANES), .SAMP_W(SAMP_W), .GAIN_W(GAIN_W)
    ) u_weight (
      .clk(clk), .rst(rst), .en(v1),
      .din_i(al_i[c*WORD_W +: WORD_W]), .din_q(al_q[c*WORD_W +: WORD_W]),
      .gain(gain_s1[c*GAIN_W +: GAIN_W]),
      .dout_i(wt_i[c*WORD_W +: WORD_W]), .dout_q(wt_q[c*WORD_W +: WORD_W])
    );
  end

  bc_sum_tree #(
    .NUM_CH(NUM_CH), .LANES(LANES), .SAMP_W(SAMP_W), .OUT_W(OUT_W)
  ) u_sum (
    .clk(clk), .rst(rst), .en(v2),
    .din_i(wt_i), .din_q(wt_q),
    .dout_i(out_i), .dout_q(out_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
    end
  end

endmodule

// File: rtl/bc_checker.sv
module bc_checker #(
  parameter int NUM_CH = 8,
  parameter int DLY_W  = 3,
  parameter int GAIN_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic                     cfg_commit,
  input logic [NUM_CH*DLY_W-1:0]  shd_dly,
  input logic [NUM_CH*GAIN_W-1:0] shd_gain,
  input logic [NUM_CH*DLY_W-1:0]  act_dly,
  input logic [NUM_CH*GAIN_W-1:0] act_gain
);

  localparam logic [GAIN_W-1:0] UNITY = {1'b1, {(GAIN_W-1){1'b0}}};

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!out_valid && act_dly == '0 && act_gain == {NUM_CH{UNITY}}));

  a_r5_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r6_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
    !cfg_commit |=> ($stable(act_dly) && $stable(act_gain)));

  a_r7_commit_copy: assert property (@(posedge clk) disable iff (rst)
    cfg_commit |=> (act_dly == $past(shd_dly) && act_gain == $past(shd_gain)));

endmodule

bind beam_combiner bc_checker #(
  .NUM_CH(NUM_CH), .DLY_W(DLY_W), .GAIN_W(GAIN_W)
) u_bc_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .cfg_commit(cfg_commit),
  .shd_dly(shd_dly), .shd_gain(shd_gain),
  .act_dly(act_dly), .act_gain(act_gain)
);

// File: tb/beam_combiner_bench.sv
module beam_combiner_bench;

  localparam int CLK_PERIOD = 4;
  localparam int NCH = 8;
  localparam int NL  = 8;
  localparam int SW  = 16;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NCH*NL*SW-1:0] in_i = '0, in_q = '0;
  logic cfg_wr = 1'b0, cfg_sel = 1'b0, cfg_commit = 1'b0;
  logic [2:0] cfg_ch = '0;
  logic [15:0] cfg_data = '0;
  logic out_valid;
  logic [NL*SW-1:0] out_i, out_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  beam_combiner u_beam_combiner (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_ch(cfg_ch), .cfg_data(cfg_data),
    .cfg_commit(cfg_commit), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  int stim_i[NCH][NL], stim_q[NCH][NL];
  bit stim_v;
  bit s_wr, s_sel, s_commit;
  int s_ch, s_data;

  int m_prev_i[NCH][NL], m_prev_q[NCH][NL];
  int m_act_d[NCH], m_act_g[NCH], m_shd_d[NCH], m_shd_g[NCH];
  logic [2:0] vhist;
  logic [NL*SW-1:0] eq_i[$], eq_q[$];

  function automatic int sat(longint v, int w);
    longint hi = (longint'(1) <<< (w-1)) - 1;
    longint lo = -(longint'(1) <<< (w-1));
    if (v > hi) return int'(hi);
    if (v < lo) return int'(lo);
    return int'(v);
  endfunction

  function automatic int wmul(int s, int g);
    longint p = longint'(s) * longint'(g);
    p = (p + 16384) >>> 15;
    return sat(p, 16);
  endfunction

  function automatic logic [NL*SW-1:0] exp_word(input int cur[NCH][NL], input int prv[NCH][NL]);
    logic [NL*SW-1:0] r;
    for (int k = 0; k < NL; k++) begin
      longint acc = 0;
      int t;
      for (int c = 0; c < NCH; c++) begin
        int d = m_act_d[c];
        int s = (k >= d) ? cur[c][k-d] : prv[c][NL+k-d];
        acc += wmul(s, m_act_g[c]);
      end
      t = sat(acc, 16);
      r[k*SW +: SW] = t[15:0];
    end
    return r;
  endfunction

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  task automatic fail_msg(string req, string what, logic [NL*SW-1:0] act, logic [NL*SW-1:0] exp);
    fails++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic check_outputs();
    checks++;
    if (out_valid !== vhist[2]) begin
      fails++;
      $display("FAIL R5 out_valid actual=%b expected=%b", out_valid, vhist[2]);
    end
    if (out_valid === 1'b1) begin
      logic [NL*SW-1:0] ei, eq;
      if (eq_i.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected word actual=valid expected=none");
      end else begin
        ei = eq_i.pop_front();
        eq = eq_q.pop_front();
        checks++;
        if (out_i !== ei) fail_msg(tag, "I beam", out_i, ei);
        checks++;
        if (out_q !== eq) fail_msg({"R8 ", tag}, "Q beam", out_q, eq);
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    check_outputs();
    in_valid = stim_v;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NL; k++) begin
        in_i[(c*NL+k)*SW +: SW] = stim_i[c][k][15:0];
        in_q[(c*NL+k)*SW +: SW] = stim_q[c][k][15:0];
      end
    cfg_wr = s_wr; cfg_sel = s_sel; cfg_ch = s_ch[2:0];
    cfg_data = s_data[15:0]; cfg_commit = s_commit;
    if (stim_v) begin
      eq_i.push_back(exp_word(stim_i, m_prev_i));
      eq_q.push_back(exp_word(stim_q, m_prev_q));
      m_prev_i = stim_i;
      m_prev_q = stim_q;
    end
    vhist = {vhist[1:0], stim_v};
    if (s_commit) begin
      m_act_d = m_shd_d;
      m_act_g = m_shd_g;
    end
    if (s_wr) begin
      if (s_sel) m_shd_g[s_ch] = s_data & 16'hFFFF;
      else       m_shd_d[s_ch] = s_data & 7;
    end
    s_wr = 0; s_commit = 0;
  endtask

  task automatic fill_rand();
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NL; k++) begin
        stim_i[c][k] = rnd16();
        stim_q[c][k] = rnd16();
      end
  endtask

  task automatic fill_const(int vi, int vq);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NL; k++) begin
        stim_i[c][k] = vi;
        stim_q[c][k] = vq;
      end
  endtask

  task automatic word(bit v);
    stim_v = v;
    cycle();
  endtask

  task automatic wr_cfg(bit sel, int ch, int data, bit commit);
    s_wr = 1; s_sel = sel; s_ch = ch; s_data = data; s_commit = commit;
    stim_v = 0;
    cycle();
  endtask

  task automatic commit_only();
    s_commit = 1;
    stim_v = 0;
    cycle();
  endtask

  task automatic flush();
    stim_v = 0;
    repeat (5) cycle();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int c = 0; c < NCH; c++) begin
      m_act_d[c] = 0; m_shd_d[c] = 0;
      m_act_g[c] = 32768; m_shd_g[c] = 32768;
      for (int k = 0; k < NL; k++) begin
        m_prev_i[c][k] = 0; m_prev_q[c][k] = 0;
      end
    end
    vhist = '0;
    s_wr = 0; s_commit = 0; s_sel = 0; s_ch = 0; s_data = 0; stim_v = 0;
    fill_const(0, 0);
    in_valid = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;

    // R1: reset state visible at the ports
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 out_valid after reset actual=%b expected=0", out_valid);
    end

    // R1: defaults give a plain sum with zero history
    tag = "R1";
    for (int n = 0; n < 4; n++) begin fill_rand(); word(1); end
    flush();

    // R4: positive and negative saturation of the sum
    tag = "R4";
    fill_const(32767, -32768); word(1);
    fill_const(-32768, 32767); word(1);
    fill_const(4000, -4000);   word(1);
    flush();

    // R3: gain rounding and product saturation on channel 0 only
    tag = "R3";
    for (int c = 1; c < NCH; c++) wr_cfg(1, c, 0, 0);
    wr_cfg(1, 0, 16'hFFFF, 1);
    fill_const(-32768, 32767); word(1);
    wr_cfg(1, 0, 16'h4000, 1);
    fill_const(1, -1); word(1);
    fill_const(3, -3); word(1);
    for (int n = 0; n < 3; n++) begin fill_rand(); word(1); end
    flush();

    // R2 and R9: distinct delays per channel, upper data bits set on some writes
    tag = "R2";
    for (int c = 0; c < NCH; c++) begin
      wr_cfg(1, c, 16'h2000 + c * 512, 0);
      wr_cfg(0, c, (c % 2 == 1) ? (16'hFFF8 | (7 - c)) : (7 - c), 0);
    end
    tag = "R9";
    commit_only();
    for (int n = 0; n < 6; n++) begin fill_rand(); word(1); end
    tag = "R2";
    for (int n = 0; n < 6; n++) begin fill_rand(); word(n % 2 == 0); end
    flush();

    // R6: shadow writes without commit leave outputs on the old set
    tag = "R6";
    for (int c = 0; c < NCH; c++) begin
      wr_cfg(0, c, c, 0);
      wr_cfg(1, c, 16'h7000, 0);
    end
    for (int n = 0; n < 4; n++) begin fill_rand(); word(1); end
    flush();

    // R7: commit on the same edge as a data word and a new write
    tag = "R7";
    fill_rand();
    stim_v = 1; s_wr = 1; s_sel = 1; s_ch = 3; s_data = 16'h1234; s_commit = 1;
    cycle();
    for (int n = 0; n < 3; n++) begin fill_rand(); word(1); end
    commit_only();
    for (int n = 0; n < 3; n++) begin fill_rand(); word(1); end
    flush();

    // R5: random gaps in valid
    tag = "R5";
    for (int n = 0; n < 60; n++) begin fill_rand(); word($urandom_range(0, 3) != 0); end
    flush();

    // mixed random steering updates and data
    tag = "R2 R3 R4 R7";
    for (int n = 0; n < 400; n++) begin
      fill_rand();
      stim_v = ($urandom_range(0, 4) != 0);
      if ($urandom_range(0, 2) == 0) begin
        s_wr = 1; s_sel = $urandom_range(0, 1); s_ch = $urandom_range(0, 7);
        s_data = $urandom_range(0, 65535);
      end
      s_commit = ($urandom_range(0, 9) == 0);
      cycle();
    end
    flush();

    checks++;
    if (eq_i.size() != 0) begin
      fails++;
      $display("FAIL R5 pending words actual=%0d expected=0", eq_i.size());
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule